// File: doc/BRIEF.md
# Sector Single-Bit Hamming ECC

The block computes a 24-bit Hamming-style check code over one sector of data that arrives one byte per clock. After the last byte it compares the computed code with the three check bytes that were stored next to the sector. It then reports whether the sector is clean, holds one flipped data bit it can name, holds one flipped bit inside the stored check bytes only, or cannot be repaired.

A start pulse opens a sector and clears the parity state. Bytes are taken on cycles where the valid strobe is high, and gaps between bytes are allowed. One cycle after the final byte of the sector a single-cycle done pulse marks the point where the code and the verdict are ready. When a data bit is correctable, the byte index and bit index are presented so that the caller can flip that bit in its own buffer. The code is inverted before output, so an erased sector (every byte 0xFF) read together with erased check bytes is reported as clean.

Top module: `sector_hamming_ecc`

## Requirements
- R1: After reset done_o is low and ecc_o reads 0xFFFFFF, which is the inverted code of an empty accumulation.
- R2: A start_i pulse with valid_i low clears the accumulated parity, so ecc_o returns to 0xFFFFFF and done_o stays low.
- R3: For a data bit set at byte index a and bit index k, let pos = {a[8:0], k[2:0]} (12 bits). Bit j of the upper group is the parity of all set bits whose pos bit j is 1, bit j of the lower group is the parity of all set bits whose pos bit j is 0, and ecc_o = ~{upper, lower}, with ecc_o[7:0] the first check byte, ecc_o[15:8] the second and ecc_o[23:16] the third.
- R4: A sector of all 0xFF bytes yields ecc_o = 0xFFFFFF and, against stored 0xFFFFFF, status clean.
- R5: done_o is high for exactly one cycle, in the cycle after the cycle in which the SECTOR_BYTES-th valid byte is taken.
- R6: Valid bytes presented after the last byte of a sector and before the next start_i have no effect on ecc_o.
- R7: status_o encoding: 0 clean, 1 data bit corrected, 2 error in the stored check bytes only, 3 uncorrectable. With diff = ecc_o XOR stored_ecc_i, a zero diff gives status 0.
- R8: When diff[23:12] XOR diff[11:0] is 0xFFF and diff[23:15] is below SECTOR_BYTES, status is 1, err_byte_o = diff[23:15] and err_bit_o = diff[14:12].
- R9: When diff[23:12] XOR diff[11:0] is 0xFFF but diff[23:15] is not below SECTOR_BYTES, status is 3.
- R10: When diff has exactly one bit set, status is 2 and the data is left as it is.
- R11: Any other nonzero diff, such as two flipped data bits, gives status 3.
- R12: Cycles with valid_i low neither advance the byte index nor change the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new sector and clears the parity state |
| valid_i | input | 1 | data_i holds a sector byte this cycle |
| data_i | input | 8 | Sector byte |
| stored_ecc_i | input | 24 | Stored check bytes, first byte in bits 7:0 |
| ecc_o | output | 24 | Computed check bytes, first byte in bits 7:0 |
| done_o | output | 1 | One-cycle pulse after the last sector byte |
| status_o | output | 2 | Verdict: 0 clean, 1 corrected, 2 check-byte error, 3 uncorrectable |
| err_byte_o | output | 9 | Byte index of the bit to flip |
| err_bit_o | output | 3 | Bit index of the bit to flip |

## Verification
The assertions assume that start_i is never raised in the middle of a sector in a way that races the done pulse, and that stored_ecc_i is held steady while status_o is sampled. They also take the verdict outputs as meaningful only in the done cycle and after it. The bench opens each sector with an isolated start pulse and inserts random idle gaps between bytes. It changes the stored bytes only while no sector is being closed, and derives every corrupted code from a known bit position. A second instance with a 384-byte sector makes the out-of-range byte index reachable.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_ECC_ONLY = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc1_accum.sv
module ecc1_accum #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int GRP_W        = ADDR_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic [GRP_W-1:0] grp_hi_o,
  output logic [GRP_W-1:0] grp_lo_o,
  output logic             done_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(SECTOR_BYTES - 1);

  logic [ADDR_W-1:0] cnt_q, cnt_d, cur_cnt;
  logic              full_q, full_d, done_q;
  logic [GRP_W-1:0]  acc_hi_q, acc_lo_q, acc_hi_d, acc_lo_d;
  logic [GRP_W-1:0]  add_hi, add_lo;
  logic [2:0]        col_hi, col_lo;
  logic              take, last, byte_par;

  assign take    = valid_i && (start_i || !full_q);
  assign cur_cnt = start_i ? '0 : cnt_q;
  assign last    = take && (cur_cnt == LAST_IDX);

  // column parities by bit index, line parities by byte index
  always_comb begin
    col_hi = '0;
    col_lo = '0;
    for (int j = 0; j < 3; j++) begin
      for (int k = 0; k < 8; k++) begin
        if (k[j]) col_hi[j] = col_hi[j] ^ data_i[k];
        else      col_lo[j] = col_lo[j] ^ data_i[k];
      end
    end
    byte_par = ^data_i;
    add_hi = {(byte_par ? cur_cnt  : '0), col_hi};
    add_lo = {(byte_par ? ~cur_cnt : '0), col_lo};
  end

  always_comb begin
    acc_hi_d = start_i ? '0 : acc_hi_q;
    acc_lo_d = start_i ? '0 : acc_lo_q;
    if (take) begin
      acc_hi_d = acc_hi_d ^ add_hi;
      acc_lo_d = acc_lo_d ^ add_lo;
    end
    cnt_d  = cur_cnt + ADDR_W'(take);
    full_d = last ? 1'b1 : (start_i ? 1'b0 : full_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
      cnt_q    <= cnt_d;
      full_q   <= full_d;
      done_q   <= last;
    end
  end

  assign grp_hi_o = acc_hi_q;
  assign grp_lo_o = acc_lo_q;
  assign done_o   = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !start_i) |=> ($stable(acc_hi_q) && $stable(acc_lo_q)));

  // R12
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> ($stable(acc_hi_q) && $stable(cnt_q)));
endmodule

// File: rtl/ecc1_check.sv
module ecc1_check
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int GRP_W        = ADDR_W + 3,
  parameter int CODE_W       = 2 * GRP_W
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output ecc_status_e       status_o,
  output logic [ADDR_W-1:0] err_byte_o,
  output logic [2:0]        err_bit_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic [GRP_W-1:0]  d_hi, d_lo;
  logic              paired, in_range, single;

  assign diff       = calc_i ^ stored_i;
  assign d_hi       = diff[CODE_W-1:GRP_W];
  assign d_lo       = diff[GRP_W-1:0];
  assign paired     = &(d_hi ^ d_lo);
  assign err_byte_o = d_hi[GRP_W-1:3];
  assign err_bit_o  = d_hi[2:0];
  assign in_range   = {1'b0, err_byte_o} < LIMIT;
  assign single     = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

  always_comb begin
    if (diff == '0)   status_o = ST_CLEAN;
    else if (paired)  status_o = in_range ? ST_FIXED : ST_UNCORR;
    else if (single)  status_o = ST_ECC_ONLY;
    else              status_o = ST_UNCORR;
  end
endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int GRP_W        = ADDR_W + 3,
  parameter int CODE_W       = 2 * GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic [CODE_W-1:0] stored_ecc_i,
  output logic [CODE_W-1:0] ecc_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] err_byte_o,
  output logic [2:0]        err_bit_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SECTOR_BYTES);

  logic [GRP_W-1:0] grp_hi, grp_lo;
  ecc_status_e      status_w;

  ecc1_accum #(
    .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W), .GRP_W(GRP_W)
  ) i_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .grp_hi_o(grp_hi),
    .grp_lo_o(grp_lo),
    .done_o  (done_o)
  );

  // inverted so an erased sector with erased check bytes is clean
  assign ecc_o = ~{grp_hi, grp_lo};

  ecc1_check #(
    .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W), .GRP_W(GRP_W), .CODE_W(CODE_W)
  ) i_check (
    .calc_i    (ecc_o),
    .stored_i  (stored_ecc_i),
    .status_o  (status_w),
    .err_byte_o(err_byte_o),
    .err_bit_o (err_bit_o)
  );

  assign status_o = status_w;

  // R5
  done_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  // R8
  fixed_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |->
      ({1'b0, err_byte_o} < LIMIT && $countones(ecc_o ^ stored_ecc_i) == GRP_W));

  // R10
  ecc_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |-> $countones(ecc_o ^ stored_ecc_i) == 1);

  // R7
  clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd0) |-> ecc_o == stored_ecc_i);
endmodule

// File: tb/test_sector_hamming_ecc.sv
module test_sector_hamming_ecc;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 512;
  localparam int NB2 = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, valid = 1'b0;
  logic        start2 = 1'b0, valid2 = 1'b0;
  logic [7:0]  data = '0;
  logic [23:0] stored = '0, stored2 = '0;
  logic [23:0] ecc, ecc2;
  logic        done, done2;
  logic [1:0]  status, status2;
  logic [8:0]  ebyte, ebyte2;
  logic [2:0]  ebit, ebit2;

  logic [7:0]  sec [NB];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_hamming_ecc i_sector_hamming_ecc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .data_i(data),
    .stored_ecc_i(stored), .ecc_o(ecc), .done_o(done), .status_o(status),
    .err_byte_o(ebyte), .err_bit_o(ebit));

  sector_hamming_ecc #(.SECTOR_BYTES(NB2)) i_sector_hamming_ecc_short (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start2), .valid_i(valid2), .data_i(data),
    .stored_ecc_i(stored2), .ecc_o(ecc2), .done_o(done2), .status_o(status2),
    .err_byte_o(ebyte2), .err_bit_o(ebit2));

  function automatic logic [23:0] model(input int n);
    logic [11:0] up = '0, lo = '0, pos;
    for (int a = 0; a < n; a++)
      for (int k = 0; k < 8; k++)
        if (sec[a][k]) begin
          pos = {9'(a), 3'(k)};
          up ^= pos;
          lo ^= ~pos;
        end
    return ~{up, lo};
  endfunction

  function automatic logic [23:0] pair_diff(input int a, input int k);
    logic [11:0] pos = {9'(a), 3'(k)};
    return {pos, ~pos};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
  endtask

  // leaves the bench at the negedge right after the last byte was taken
  task automatic stream(input int n, input bit two);
    @(negedge clk);
    if (two) start2 = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; start2 = 1'b0;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 4 == 0) begin
        valid = 1'b0; valid2 = 1'b0;
        repeat (1 + $urandom % 3) @(negedge clk);
      end
      data = sec[i];
      if (two) valid2 = 1'b1; else valid = 1'b1;
      if (i == n - 1) begin
        if (two) chk(done2 == 1'b0, "R5 early", 32'(done2), 0);
        else     chk(done == 1'b0, "R5 early", 32'(done), 0);
      end
      @(negedge clk);
    end
    valid = 1'b0; valid2 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] exp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(ecc == 24'hFFFFFF, "R1 ecc", 32'(ecc), 32'hFFFFFF);

    // R4 erased sector
    for (int i = 0; i < NB; i++) sec[i] = 8'hFF;
    stored = 24'hFFFFFF;
    stream(NB, 1'b0);
    chk(done == 1'b1, "R5 done", 32'(done), 1);
    chk(ecc == 24'hFFFFFF, "R4 ecc", 32'(ecc), 32'hFFFFFF);
    chk(status == 2'd0, "R4 status", 32'(status), 0);
    @(negedge clk);
    chk(done == 1'b0, "R5 single", 32'(done), 0);

    // R3 R7 R12 random clean sectors with idle gaps
    for (int t = 0; t < 3; t++) begin
      fill_random();
      exp = model(NB);
      stored = exp;
      stream(NB, 1'b0);
      chk(done == 1'b1, "R5 done", 32'(done), 1);
      chk(ecc == exp, "R3 R12 ecc", 32'(ecc), 32'(exp));
      chk(status == 2'd0, "R7 status", 32'(status), 0);
    end

    // R8 single data bit flips, corners first
    for (int t = 0; t < 5; t++) begin
      int b, k;
      b = (t == 0) ? 0 : (t == 1) ? NB - 1 : int'($urandom % NB);
      k = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom % 8);
      fill_random();
      stored = model(NB);
      sec[b][k] = ~sec[b][k];
      stream(NB, 1'b0);
      chk(status == 2'd1, "R8 status", 32'(status), 1);
      chk(ebyte == 9'(b), "R8 byte", 32'(ebyte), 32'(b));
      chk(ebit == 3'(k), "R8 bit", 32'(ebit), 32'(k));
    end

    // R10 single flipped stored check bit
    for (int t = 0; t < 3; t++) begin
      int r;
      r = (t == 0) ? 23 : int'($urandom % 24);
      fill_random();
      exp = model(NB);
      stored = exp ^ (24'd1 << r);
      stream(NB, 1'b0);
      chk(status == 2'd2, "R10 status", 32'(status), 2);
      chk(ecc == exp, "R10 ecc", 32'(ecc), 32'(exp));
    end

    // R11 two flipped data bits
    fill_random();
    stored = model(NB);
    sec[3][1] = ~sec[3][1];
    sec[200][6] = ~sec[200][6];
    stream(NB, 1'b0);
    chk(status == 2'd3, "R11 status", 32'(status), 3);

    // R6 trailing bytes ignored
    fill_random();
    exp = model(NB);
    stored = exp;
    stream(NB, 1'b0);
    for (int i = 0; i < 20; i++) begin
      data = 8'($urandom | 1);
      valid = 1'b1;
      @(negedge clk);
    end
    valid = 1'b0;
    @(negedge clk);
    chk(ecc == exp, "R6 ecc", 32'(ecc), 32'(exp));
    chk(status == 2'd0, "R6 status", 32'(status), 0);

    // R2 start clears
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ecc == 24'hFFFFFF, "R2 ecc", 32'(ecc), 32'hFFFFFF);
    chk(done == 1'b0, "R2 done", 32'(done), 0);

    // R9 and R8 on a 384-byte sector
    fill_random();
    exp = model(NB2);
    stored2 = exp ^ pair_diff(400, 5);
    stream(NB2, 1'b1);
    chk(done2 == 1'b1, "R5 done short", 32'(done2), 1);
    chk(ecc2 == exp, "R3 ecc short", 32'(ecc2), 32'(exp));
    chk(status2 == 2'd3, "R9 status", 32'(status2), 3);
    stored2 = exp ^ pair_diff(100, 2);
    @(negedge clk);
    chk(status2 == 2'd1, "R8 short status", 32'(status2), 1);
    chk(ebyte2 == 9'd100, "R8 short byte", 32'(ebyte2), 100);
    chk(ebit2 == 3'd2, "R8 short bit", 32'(ebit2), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule